// File: doc/BRIEF.md
# Banked Internal Data Memory with Bit Addressing

This block is the internal data store of a small 8-bit controller core. It holds 128 bytes of low data RAM and an optional 128 bytes of upper data RAM. It also holds a 128-entry special register window that occupies the same upper address range as the upper RAM. Three access paths share this storage:

- A byte path that takes an 8-bit address and a direct/indirect flag.
- A working-register path that reaches R0 to R7 in the bank chosen by the status register.
- A bit path that reads a single bit of a byte, or sets, clears or writes it.

The controller's datapath drives all three paths. Reads are combinational from the current address. All writes commit on the rising clock edge through a single arbitrated write port. When a byte address is in the upper half, the addressing mode decides the target: an indirect access goes to the upper RAM and a direct access goes to the special registers. A bit address below 80H lands in the sixteen-byte bit area of RAM. A bit address at 80H or above lands in the special register at the eight-aligned address below it.

Top module: `idm_unit`

## Requirements
- R1: A synchronous reset sets every special register to 00H, except the stack register at direct address 81H, which becomes 07H. The status register at direct address D0H therefore reads 00H, which selects bank 0. RAM keeps its contents.
- R2: Addresses 00H to 7FH reach the same low RAM byte whether the access is direct (`byte_indirect`=0) or indirect (`byte_indirect`=1).
- R3: For addresses 80H to FFH, indirect accesses reach the upper RAM and direct accesses reach the special register window. The two are separate storage.
- R4: With `UPPER_BYTES`=0, indirect reads of 80H to FFH return 00H and indirect writes there change nothing.
- R5: Working register n (`reg_sel`) maps to low RAM byte bank*8+n. The bank is bits [4:3] of the status register at D0H: bit 4 is the high select bit and bit 3 is the low select bit.
- R6: A write to the status register changes the bank mapping from the cycle after the write edge. In the write cycle itself, register reads still use the old bank.
- R7: A bit address b below 80H selects RAM byte 20H + b[6:3] at bit position b[2:0]. So 00H is bit 0 of 20H and 7FH is bit 7 of 2FH. `bit_rdata` returns that bit.
- R8: A bit address b of 80H or above selects the special register at direct address {b[7:3],000b}, at bit position b[2:0].
- R9: `bit_op` encodes the operation: 00 none, 01 set, 10 clear, 11 write `bit_wval`. The operation is a single-cycle read-modify-write that leaves the other seven bits of the byte unchanged.
- R10: Only one write commits per cycle. A byte write beats a register write, and a register write beats a bit operation. Losing writes are dropped.
- R11: `byte_rdata`, `reg_rdata` and `bit_rdata` follow their addresses in the same cycle, with no clock edge between address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_addr | input | 8 | Byte path address |
| byte_indirect | input | 1 | 1 = indirect access, 0 = direct access |
| byte_we | input | 1 | Byte path write enable |
| byte_wdata | input | 8 | Byte path write data |
| byte_rdata | output | 8 | Byte path read data |
| reg_sel | input | 3 | Working register number 0 to 7 |
| reg_we | input | 1 | Register path write enable |
| reg_wdata | input | 8 | Register path write data |
| reg_rdata | output | 8 | Register path read data |
| bit_addr | input | 8 | Bit address |
| bit_op | input | 2 | Bit operation: 00 none, 01 set, 10 clear, 11 write |
| bit_wval | input | 1 | Value for the bit write operation |
| bit_rdata | output | 1 | Addressed bit |

## Verification
The bench writes the same upper address both ways and reads it back both ways. A design that ignores the mode would return one value for both. It reads a register in the same cycle as a status write and again one cycle later. A design that forwards the new bank early, or that bypasses the register edge, gives the wrong byte in one of those two reads. Bit operations are aimed at both ends of the RAM bit area and at the select bits of the status register. Their effect is checked both through byte reads and through bank changes, so a wrong byte offset, a wrong bit position or a clobbered neighbour bit shows up. The stimulus also issues a byte write, a register write and a bit operation together, and checks that only the byte write lands. A build without upper RAM is checked to return zero after an indirect write to the upper range.

// File: rtl/idm_pkg.sv
`timescale 1ns/1ps
package idm_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 7;
    localparam int BANK_W = 2;
    localparam int REG_W  = 3;
    localparam int POS_W  = 3;

    typedef enum logic [1:0] {
        SP_LOW   = 2'd0,
        SP_UPPER = 2'd1,
        SP_SFR   = 2'd2
    } space_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_PUT  = 2'b11
    } bit_op_e;

    typedef struct packed {
        space_e             space;
        logic [IDX_W-1:0]   idx;
    } loc_t;

    localparam logic [IDX_W-1:0]  STATUS_IDX  = 7'h50;  // direct D0H
    localparam logic [IDX_W-1:0]  STACK_IDX   = 7'h01;  // direct 81H
    localparam logic [BYTE_W-1:0] STACK_INIT  = 8'h07;
    localparam int                BANK_LO     = 3;
    localparam logic [IDX_W-1:0]  BITRAM_BASE = 7'h20;

    // Byte path: the top address bit picks low RAM or the upper range,
    // and the mode then separates upper RAM from the register window.
    function automatic loc_t map_byte(input logic [BYTE_W-1:0] a, input logic ind);
        loc_t l;
        l.idx = a[IDX_W-1:0];
        if (!a[BYTE_W-1])  l.space = SP_LOW;
        else if (ind)      l.space = SP_UPPER;
        else               l.space = SP_SFR;
        return l;
    endfunction

    function automatic loc_t map_reg(input logic [BANK_W-1:0] bank, input logic [REG_W-1:0] n);
        loc_t l;
        l.space = SP_LOW;
        l.idx   = {{(IDX_W-BANK_W-REG_W){1'b0}}, bank, n};
        return l;
    endfunction

    // Bit path: only the byte-select part of the bit address is needed here.
    function automatic loc_t map_bit(input logic [BYTE_W-1:POS_W] b);
        loc_t l;
        if (!b[BYTE_W-1]) begin
            l.space = SP_LOW;
            l.idx   = BITRAM_BASE + {{(IDX_W-4){1'b0}}, b[BYTE_W-2:POS_W]};
        end else begin
            l.space = SP_SFR;
            l.idx   = {b[BYTE_W-2:POS_W], {POS_W{1'b0}}};
        end
        return l;
    endfunction
endpackage

// File: rtl/idm_route.sv
`timescale 1ns/1ps
module idm_route
    import idm_pkg::*;
(
    input  logic [BYTE_W-1:0]     byte_addr,
    input  logic                  byte_ind,
    input  logic [REG_W-1:0]      reg_n,
    input  logic [BANK_W-1:0]     bank,
    input  logic [BYTE_W-1:POS_W] bit_byte_sel,
    output loc_t                  byte_loc,
    output loc_t                  reg_loc,
    output loc_t                  bit_loc
);
    always_comb begin
        byte_loc = map_byte(byte_addr, byte_ind);
        reg_loc  = map_reg(bank, reg_n);
        bit_loc  = map_bit(bit_byte_sel);
    end
endmodule

// File: rtl/idm_wsel.sv
`timescale 1ns/1ps
module idm_wsel
    import idm_pkg::*;
(
    input  logic              byte_we,
    input  loc_t              byte_loc,
    input  logic [BYTE_W-1:0] byte_wdata,
    input  logic              reg_we,
    input  loc_t              reg_loc,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [1:0]        bit_op,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              bit_wval,
    input  loc_t              bit_loc,
    input  logic [BYTE_W-1:0] bit_cur,
    output logic              wr_en,
    output loc_t              wr_loc,
    output logic [BYTE_W-1:0] wr_data,
    output logic              bit_val
);
    typedef struct packed {
        logic              en;
        loc_t              loc;
        logic [BYTE_W-1:0] data;
    } wreq_t;

    wreq_t             pick;
    logic [BYTE_W-1:0] merged;
    logic              new_bit;
    bit_op_e           op;

    always_comb begin
        op = bit_op_e'(bit_op);
        unique case (op)
            BOP_SET: new_bit = 1'b1;
            BOP_CLR: new_bit = 1'b0;
            BOP_PUT: new_bit = bit_wval;
            default: new_bit = bit_cur[bit_pos];
        endcase
        merged          = bit_cur;
        merged[bit_pos] = new_bit;

        if (byte_we)
            pick = '{en: 1'b1, loc: byte_loc, data: byte_wdata};
        else if (reg_we)
            pick = '{en: 1'b1, loc: reg_loc, data: reg_wdata};
        else if (op != BOP_NONE)
            pick = '{en: 1'b1, loc: bit_loc, data: merged};
        else
            pick = '{en: 1'b0, loc: byte_loc, data: byte_wdata};
    end

    assign wr_en   = pick.en;
    assign wr_loc  = pick.loc;
    assign wr_data = pick.data;
    assign bit_val = bit_cur[bit_pos];
endmodule

// File: rtl/idm_store.sv
`timescale 1ns/1ps
module idm_store
    import idm_pkg::*;
#(
    parameter int UPPER_BYTES = 128,
    parameter int NRD         = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  loc_t              rd_loc  [NRD],
    output logic [BYTE_W-1:0] rd_data [NRD],
    input  logic              wr_en,
    input  loc_t              wr_loc,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BANK_W-1:0] bank_o
);
    localparam int WIN       = 1 << IDX_W;
    localparam bit HAS_UPPER = (UPPER_BYTES != 0);

    typedef struct packed {
        logic [WIN-1:0][BYTE_W-1:0] low;
        logic [WIN-1:0][BYTE_W-1:0] sfr;
    } core_t;

    core_t                      core_d, core_q;
    logic [WIN-1:0][BYTE_W-1:0] upper_q;

    always_comb begin
        core_d = core_q;
        if (wr_en && wr_loc.space == SP_LOW)
            core_d.low[wr_loc.idx] = wr_data;
        if (wr_en && wr_loc.space == SP_SFR)
            core_d.sfr[wr_loc.idx] = wr_data;
        if (rst) begin
            core_d.sfr            = '0;
            core_d.sfr[STACK_IDX] = STACK_INIT;
        end
    end

    always_ff @(posedge clk) core_q <= core_d;

    generate
        if (HAS_UPPER) begin : g_upper
            logic [WIN-1:0][BYTE_W-1:0] upper_d;
            always_comb begin
                upper_d = upper_q;
                if (wr_en && wr_loc.space == SP_UPPER)
                    upper_d[wr_loc.idx] = wr_data;
            end
            always_ff @(posedge clk) upper_q <= upper_d;
        end else begin : g_no_upper
            assign upper_q = '0;
        end
    endgenerate

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        always_comb begin
            unique case (rd_loc[i].space)
                SP_LOW:   rd_data[i] = core_q.low[rd_loc[i].idx];
                SP_UPPER: rd_data[i] = upper_q[rd_loc[i].idx];
                SP_SFR:   rd_data[i] = core_q.sfr[rd_loc[i].idx];
                default:  rd_data[i] = '0;
            endcase
        end
    end

    assign bank_o = core_q.sfr[STATUS_IDX][BANK_LO +: BANK_W];

    // R1: one edge of reset leaves status clear and stack at its start value
    assert_reset_values_R1: assert property (@(posedge clk)
        rst |=> (core_q.sfr[STATUS_IDX] == '0 && core_q.sfr[STACK_IDX] == STACK_INIT));

    // R2: a committed low RAM write is visible at that index next cycle
    assert_low_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_loc.space == SP_LOW) |=> core_q.low[$past(wr_loc.idx)] == $past(wr_data));

    // R3: a committed register-window write is visible next cycle
    assert_sfr_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_loc.space == SP_SFR) |=> core_q.sfr[$past(wr_loc.idx)] == $past(wr_data));
endmodule

// File: rtl/idm_unit.sv
`timescale 1ns/1ps
module idm_unit
    import idm_pkg::*;
#(
    parameter int UPPER_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] byte_addr,
    input  logic       byte_indirect,
    input  logic       byte_we,
    input  logic [7:0] byte_wdata,
    output logic [7:0] byte_rdata,
    input  logic [2:0] reg_sel,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [7:0] bit_addr,
    input  logic [1:0] bit_op,
    input  logic       bit_wval,
    output logic       bit_rdata
);
    localparam int NRD    = 3;
    localparam int RD_BYT = 0;
    localparam int RD_REG = 1;
    localparam int RD_BIT = 2;

    loc_t              byte_loc, reg_loc, bit_loc;
    loc_t              rd_loc  [NRD];
    logic [BYTE_W-1:0] rd_data [NRD];
    logic [BANK_W-1:0] bank;
    logic              wr_en;
    loc_t              wr_loc;
    logic [BYTE_W-1:0] wr_data;

    idm_route u_route (
        .byte_addr    (byte_addr),
        .byte_ind     (byte_indirect),
        .reg_n        (reg_sel),
        .bank         (bank),
        .bit_byte_sel (bit_addr[BYTE_W-1:POS_W]),
        .byte_loc     (byte_loc),
        .reg_loc      (reg_loc),
        .bit_loc      (bit_loc)
    );

    assign rd_loc[RD_BYT] = byte_loc;
    assign rd_loc[RD_REG] = reg_loc;
    assign rd_loc[RD_BIT] = bit_loc;

    idm_store #(.UPPER_BYTES(UPPER_BYTES), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_loc  (rd_loc),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_loc  (wr_loc),
        .wr_data (wr_data),
        .bank_o  (bank)
    );

    idm_wsel u_wsel (
        .byte_we    (byte_we),
        .byte_loc   (byte_loc),
        .byte_wdata (byte_wdata),
        .reg_we     (reg_we),
        .reg_loc    (reg_loc),
        .reg_wdata  (reg_wdata),
        .bit_op     (bit_op),
        .bit_pos    (bit_addr[POS_W-1:0]),
        .bit_wval   (bit_wval),
        .bit_loc    (bit_loc),
        .bit_cur    (rd_data[RD_BIT]),
        .wr_en      (wr_en),
        .wr_loc     (wr_loc),
        .wr_data    (wr_data),
        .bit_val    (bit_rdata)
    );

    assign byte_rdata = rd_data[RD_BYT];
    assign reg_rdata  = rd_data[RD_REG];

    // R10: a byte write always owns the single write port
    assert_byte_first_R10: assert property (@(posedge clk) disable iff (rst)
        byte_we |-> (wr_en && wr_loc == byte_loc && wr_data == byte_wdata));

    // R9: a lone bit operation alters at most one bit of its byte
    assert_bit_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (!byte_we && !reg_we && bit_op != 2'b00)
            |-> (wr_en && wr_loc == bit_loc && $countones(wr_data ^ rd_data[RD_BIT]) <= 1));

    // R6: a status write moves the bank on the following cycle
    assert_bank_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_loc.space == SP_SFR && wr_loc.idx == STATUS_IDX)
            |=> bank == $past(wr_data[BANK_LO +: BANK_W]));
endmodule

// File: tb/idm_unit_tb_top.sv
`timescale 1ns/1ps
module idm_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] byte_addr = '0;
    logic       byte_indirect = 1'b0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_wdata = '0;
    logic [7:0] byte_rdata, byte_rdata0;
    logic [2:0] reg_sel = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, reg_rdata0;
    logic [7:0] bit_addr = '0;
    logic [1:0] bit_op = '0;
    logic       bit_wval = 1'b0;
    logic       bit_rdata, bit_rdata0;

    always #2.5 clk = ~clk;

    idm_unit #(.UPPER_BYTES(128)) dut_i (
        .clk(clk), .rst(rst), .byte_addr(byte_addr), .byte_indirect(byte_indirect),
        .byte_we(byte_we), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_addr(bit_addr), .bit_op(bit_op), .bit_wval(bit_wval), .bit_rdata(bit_rdata));

    idm_unit #(.UPPER_BYTES(0)) dut0_i (
        .clk(clk), .rst(rst), .byte_addr(byte_addr), .byte_indirect(byte_indirect),
        .byte_we(byte_we), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata0),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata0),
        .bit_addr(bit_addr), .bit_op(bit_op), .bit_wval(bit_wval), .bit_rdata(bit_rdata0));

    // ---------------- reference model built from the requirements ----------
    logic [7:0] m_lo [128];
    logic [7:0] m_up [128];
    logic [7:0] m_sf [128];

    function automatic logic [7:0] m_get(input logic [7:0] a, input logic ind);
        if (!a[7])   return m_lo[a[6:0]];
        else if (ind) return m_up[a[6:0]];
        else          return m_sf[a[6:0]];
    endfunction

    task automatic m_put(input logic [7:0] a, input logic ind, input logic [7:0] d);
        if (!a[7])    m_lo[a[6:0]] = d;
        else if (ind) m_up[a[6:0]] = d;
        else          m_sf[a[6:0]] = d;
    endtask

    function automatic logic [7:0] m_bank_addr(input logic [2:0] n);
        return {3'b000, m_sf[7'h50][4:3], n};
    endfunction

    function automatic logic [7:0] m_bit_byte(input logic [7:0] b);
        if (!b[7]) return 8'h20 + {4'h0, b[6:3]};
        else       return {b[7:3], 3'b000};
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [1:0] port;   // 0 byte, 1 reg, 2 bit, 3 byte of no-upper build
        logic [7:0] exp;
        logic [3:0] req;
    } item_t;

    item_t sbq[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    initial begin
        forever begin
            @(sample_ev);
            while (sbq.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sbq.pop_front();
                case (it.port)
                    2'd0: act = byte_rdata;
                    2'd1: act = reg_rdata;
                    2'd2: act = {7'b0, bit_rdata};
                    default: act = byte_rdata0;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL R%0d port %0d actual %h expected %h", it.req, it.port, act, it.exp);
                end
            end
        end
    end

    task automatic clear_in();
        byte_we = 1'b0; reg_we = 1'b0; bit_op = 2'b00; bit_wval = 1'b0;
    endtask

    task automatic push(input logic [1:0] port, input logic [7:0] exp, input int req);
        sbq.push_back('{port: port, exp: exp, req: 4'(req)});
        ->sample_ev;
    endtask

    // ---------------- driver tasks ----------------
    task automatic wr_byte(input logic [7:0] a, input logic ind, input logic [7:0] d);
        @(negedge clk); clear_in();
        byte_addr = a; byte_indirect = ind; byte_wdata = d; byte_we = 1'b1;
        @(posedge clk); m_put(a, ind, d);
    endtask

    task automatic wr_reg(input logic [2:0] n, input logic [7:0] d);
        @(negedge clk); clear_in();
        reg_sel = n; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); m_put(m_bank_addr(n), 1'b0, d);
    endtask

    task automatic do_bit(input logic [7:0] b, input logic [1:0] op, input logic v);
        logic [7:0] ba, cur;
        @(negedge clk); clear_in();
        bit_addr = b; bit_op = op; bit_wval = v;
        @(posedge clk);
        ba  = m_bit_byte(b);
        cur = m_get(ba, 1'b0);
        case (op)
            2'b01: cur[b[2:0]] = 1'b1;
            2'b10: cur[b[2:0]] = 1'b0;
            2'b11: cur[b[2:0]] = v;
            default: ;
        endcase
        m_put(ba, 1'b0, cur);
    endtask

    // Reads sample 1 ns after the address changes, with no edge between (R11).
    task automatic rd_byte(input logic [7:0] a, input logic ind, input int req);
        @(negedge clk); clear_in();
        byte_addr = a; byte_indirect = ind;
        #1 push(2'd0, m_get(a, ind), req);
    endtask

    task automatic rd_reg(input logic [2:0] n, input int req);
        @(negedge clk); clear_in();
        reg_sel = n;
        #1 push(2'd1, m_get(m_bank_addr(n), 1'b0), req);
    endtask

    task automatic rd_bit(input logic [7:0] b, input int req);
        logic [7:0] v;
        @(negedge clk); clear_in();
        bit_addr = b;
        v = m_get(m_bit_byte(b), 1'b0);
        #1 push(2'd2, {7'b0, v[b[2:0]]}, req);
    endtask

    task automatic rd_byte_noup(input logic [7:0] a, input logic ind, input int req);
        @(negedge clk); clear_in();
        byte_addr = a; byte_indirect = ind;
        #1 push(2'd3, (a[7] && ind) ? 8'h00 : m_get(a, ind), req);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: all requirements, actual hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m_sf[i] = 8'h00;
        m_sf[7'h01] = 8'h07;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset values of status and stack
        rd_byte(8'hD0, 1'b0, 1);
        rd_byte(8'h81, 1'b0, 1);

        // R2: low RAM seen alike by both modes; R11 same-cycle reads
        wr_byte(8'h30, 1'b0, 8'hA5);
        rd_byte(8'h30, 1'b1, 2);
        wr_byte(8'h45, 1'b1, 8'h3C);
        rd_byte(8'h45, 1'b0, 11);

        // R3: upper range split by mode
        wr_byte(8'h90, 1'b1, 8'h11);
        wr_byte(8'h90, 1'b0, 8'h22);
        rd_byte(8'h90, 1'b1, 3);
        rd_byte(8'h90, 1'b0, 3);
        wr_byte(8'hA0, 1'b1, 8'h55);
        rd_byte(8'hA0, 1'b1, 3);

        // R4: build without upper RAM returns zero after an indirect write
        rd_byte_noup(8'hA0, 1'b1, 4);
        rd_byte_noup(8'h90, 1'b0, 4);

        // R5: bank 0 register maps to its byte
        wr_reg(3'd3, 8'h33);
        rd_byte(8'h03, 1'b0, 5);

        // R6: status write; register read in the same cycle uses old bank
        @(negedge clk); clear_in();
        byte_addr = 8'hD0; byte_indirect = 1'b0; byte_wdata = 8'h18; byte_we = 1'b1;
        reg_sel = 3'd3;
        #1 push(2'd1, m_get(8'h03, 1'b0), 6);
        @(posedge clk); m_put(8'hD0, 1'b0, 8'h18);
        wr_reg(3'd3, 8'h77);
        rd_byte(8'h1B, 1'b0, 5);
        rd_reg(3'd3, 6);
        wr_byte(8'hD0, 1'b0, 8'h00);

        // R7 and R9: RAM bit area edges and bit writes
        wr_byte(8'h20, 1'b0, 8'h00);
        wr_byte(8'h2F, 1'b0, 8'h00);
        wr_byte(8'h26, 1'b0, 8'h00);
        do_bit(8'h00, 2'b01, 1'b0);
        rd_byte(8'h20, 1'b0, 7);
        do_bit(8'h7F, 2'b01, 1'b0);
        rd_byte(8'h2F, 1'b0, 7);
        do_bit(8'h35, 2'b11, 1'b1);
        rd_byte(8'h26, 1'b0, 7);
        rd_bit(8'h35, 7);
        do_bit(8'h35, 2'b11, 1'b0);
        rd_bit(8'h35, 9);
        wr_byte(8'h2A, 1'b0, 8'hFF);
        do_bit(8'h52, 2'b10, 1'b0);
        rd_byte(8'h2A, 1'b0, 9);
        do_bit(8'h52, 2'b00, 1'b1);
        rd_byte(8'h2A, 1'b0, 9);

        // R8: bit 3 of the status register selects bank 1
        do_bit(8'hD3, 2'b01, 1'b0);
        rd_byte(8'hD0, 1'b0, 8);
        rd_bit(8'hD3, 8);
        wr_reg(3'd0, 8'h9E);
        rd_byte(8'h08, 1'b0, 8);

        // R10: three simultaneous writers, only the byte write lands
        wr_byte(8'h0D, 1'b0, 8'h44);
        @(negedge clk); clear_in();
        byte_addr = 8'h05; byte_indirect = 1'b0; byte_wdata = 8'hAA; byte_we = 1'b1;
        reg_sel = 3'd5; reg_wdata = 8'hBB; reg_we = 1'b1;
        bit_addr = 8'h00; bit_op = 2'b10;
        @(posedge clk); m_put(8'h05, 1'b0, 8'hAA);
        rd_byte(8'h05, 1'b0, 10);
        rd_byte(8'h0D, 1'b0, 10);
        rd_byte(8'h20, 1'b0, 10);
        // register write beats bit operation
        @(negedge clk); clear_in();
        reg_sel = 3'd5; reg_wdata = 8'hC3; reg_we = 1'b1;
        bit_addr = 8'h00; bit_op = 2'b10;
        @(posedge clk); m_put(8'h0D, 1'b0, 8'hC3);
        rd_byte(8'h0D, 1'b0, 10);
        rd_bit(8'h00, 10);

        @(negedge clk); clear_in();
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule